// File: doc/BRIEF.md
# Streaming DMA Register Port

This block is the register front end a streaming peripheral places between its core logic and a DMA engine. A host reaches it through a pipelined Wishbone slave on the bus clock. The core logic runs on its own clock and sees plain push and pop ports. The register window holds five kinds of state: a start control, two status bits driven by the DMA side, a 32-bit word count for the next transfer, a core-to-bus queue of data words each tagged with an end-of-transfer marker, and a bus-to-core queue of data words.

Each queue holds 256 entries and crosses between the two clocks through Gray-coded pointers. The host can observe both queues' fill level, full and empty state through status words. The core side sees the same flags through dedicated pins. When the host writes 1 to the start bit, the core side receives exactly one clock-wide start pulse. It receives, at the same time, the word count that was programmed when the start was written.

Top module: `dma_stream_regs`

## Requirements
- R1: Every accepted Wishbone strobe (cyc and stb high) is answered by wb_ack exactly one bus clock later, and wb_ack is low in every other cycle. wb_stall, wb_err, wb_rty and wb_int are always 0.
- R2: Writing a word with bit 0 set to byte offset 0x00 gives exactly one core_start pulse, one core clock wide. Writing bit 0 as 0 gives no pulse. Bit 0 of offset 0x00 always reads as 0.
- R3: Offset 0x00 reads dma_done in bit 1 and dma_ovf in bit 2, sampled through a two-flop synchronizer on the bus clock. Bus writes to those bits have no effect.
- R4: Offset 0x04 is a 32-bit read/write word count. core_xfer_count takes the value the count held when the start was written, and it changes only in the cycle core_start is high.
- R5: core_push stores {core_push_last, core_push_data} in the core-to-bus queue. A read of offset 0x08 returns the oldest word and removes it. Bit 0 of offset 0x0C returns the end marker of the most recently removed entry until the next removal.
- R6: A read of offset 0x08 while the core-to-bus queue is empty returns 0 and removes nothing.
- R7: A write to offset 0x14 stores the word in the bus-to-core queue, and a write while that queue is full is dropped. core_pop_data shows the oldest entry, and core_pop removes it.
- R8: The status words at offset 0x10 (core-to-bus) and 0x18 (bus-to-core) carry the fill count in bits 8:0, full in bit 16 and empty in bit 17. All other bits are 0. They are exact once the synchronizer latency has passed.
- R9: The core side sees full, empty and a 9-bit count for both queues. A core_push while the core-to-bus queue is full is dropped.
- R10: Both queues keep first-in first-out order over the whole 256-entry depth.
- R11: Reads of offsets 0x1C and up, of misaligned addresses and of any address with bits above bit 4 set return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus and DMA-side clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | ADR_W | Byte address |
| wb_dat_i | input | DW | Write data |
| wb_dat_o | output | DW | Read data, valid with wb_ack |
| wb_ack | output | 1 | Acknowledge |
| wb_stall | output | 1 | Pipeline stall, always 0 |
| wb_err | output | 1 | Error, always 0 |
| wb_rty | output | 1 | Retry, always 0 |
| wb_int | output | 1 | Interrupt, always 0 |
| dma_done | input | 1 | Transfer-complete status from the DMA side |
| dma_ovf | input | 1 | Overflow status from the DMA side |
| core_clk | input | 1 | Core data clock |
| core_rst_n | input | 1 | Synchronous active-low reset, core domain |
| core_start | output | 1 | One-cycle start pulse |
| core_xfer_count | output | DW | Word count delivered with the start |
| core_push | input | 1 | Store into the core-to-bus queue |
| core_push_data | input | DW | Word to store |
| core_push_last | input | 1 | End-of-transfer marker for the stored word |
| core_c2b_full | output | 1 | Core-to-bus queue full |
| core_c2b_empty | output | 1 | Core-to-bus queue empty |
| core_c2b_count | output | AW+1 | Core-to-bus fill count |
| core_pop | input | 1 | Remove from the bus-to-core queue |
| core_pop_data | output | DW | Oldest bus-to-core word |
| core_b2c_full | output | 1 | Bus-to-core queue full |
| core_b2c_empty | output | 1 | Bus-to-core queue empty |
| core_b2c_count | output | AW+1 | Bus-to-core fill count |

## Verification
Each queue is filled to all 256 entries with an arithmetic word pattern, one extra store is offered, and the queue is then drained. A reordered, lost or duplicated word, or a full queue that still takes data, shows as a pattern mismatch or as a wrong count in the status word. The core-to-bus pattern sets the end marker on every sixteenth word, so a marker taken from the wrong entry cannot pass. The start path is swept with writes of bit 0 as 0 and as 1 and with a changing count, which separates spurious or missing pulses from stale counts. All four combinations of the DMA status inputs are read back, including after a bus write that tries to set them.

// File: rtl/dma_stream_pkg.sv
// Shared register decode and bit positions for the streaming DMA register port.
// Assumes: byte addresses, 32-bit words, register index taken from address bits 4:2.
package dma_stream_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL     = 3'd0,
        SEL_COUNT    = 3'd1,
        SEL_C2B_DATA = 3'd2,
        SEL_C2B_LAST = 3'd3,
        SEL_C2B_STAT = 3'd4,
        SEL_B2C_DATA = 3'd5,
        SEL_B2C_STAT = 3'd6
    } reg_sel_e;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_DONE_BIT  = 1;
    localparam int CTRL_OVF_BIT   = 2;
    localparam int STAT_FULL_BIT  = 16;
    localparam int STAT_EMPTY_BIT = 17;

endpackage

// File: rtl/dma_sync_vec.sv
// Two-flop synchronizer for a vector of independent bits or a Gray code.
// Assumes: the source changes at most one bit at a time when the bits form a code.
module dma_sync_vec #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Capture, then settle, the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dma_fifo_cdc.sv
// Dual-clock queue with Gray-coded pointers and 2^AW entries.
// Full and count on the write side and empty and count on the read side are
// conservative: they lag the far side by the synchronizer latency.
// The read data shows the oldest entry without a read cycle (fall-through).
// Assumes: each side is reset while its own clock runs.
module dma_fifo_cdc #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    output logic          wr_empty,
    output logic [AW:0]   wr_count,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty,
    output logic          rd_full,
    output logic [AW:0]   rd_count
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r;
    logic          push, pop;

    assign wr_count = wbin - from_gray(rgray_w);
    assign wr_full  = (wr_count == PW'(DEPTH));
    assign wr_empty = (wr_count == '0);
    assign push     = wr_en && !wr_full;

    assign rd_count = from_gray(wgray_r) - rbin;
    assign rd_empty = (rd_count == '0);
    assign rd_full  = (rd_count == PW'(DEPTH));
    assign pop      = rd_en && !rd_empty;
    assign rd_data  = mem[rbin[AW-1:0]];

    // Advance the write pointer in binary and Gray form.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin + 1'b1;
            wgray <= to_gray(wbin + 1'b1);
        end
    end

    // Store the accepted word.
    always_ff @(posedge wr_clk) begin
        if (push) mem[wbin[AW-1:0]] <= wr_data;
    end

    // Advance the read pointer in binary and Gray form.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin + 1'b1;
            rgray <= to_gray(rbin + 1'b1);
        end
    end

    dma_sync_vec #(.W(PW)) u_rd_to_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w)
    );
    dma_sync_vec #(.W(PW)) u_wr_to_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r)
    );

    AST_WGRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R10
    AST_RGRAY_ONE_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R10
    AST_WCOUNT_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_count <= PW'(DEPTH)); // R8
    AST_RCOUNT_BOUND: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_count <= PW'(DEPTH)); // R8
endmodule

// File: rtl/dma_start_xing.sv
// Carries a start request and its word count from the bus clock to the core clock.
// A request flips a toggle; the far side synchronizes and edge-detects it.
// The count is held in a source register that changes only with a new request.
// Assumes: requests are spaced far enough apart for the far side to see each toggle.
module dma_start_xing #(
    parameter int CW = 32
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic          src_fire,
    input  logic [CW-1:0] src_count,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    output logic          dst_pulse,
    output logic [CW-1:0] dst_count
);
    logic          tgl_q;
    logic [CW-1:0] held_q;
    logic          tgl_s, tgl_prev;

    // Flip the toggle and hold the count for each request.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            tgl_q  <= 1'b0;
            held_q <= '0;
        end else if (src_fire) begin
            tgl_q  <= ~tgl_q;
            held_q <= src_count;
        end
    end

    dma_sync_vec #(.W(1)) u_tgl_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(tgl_q), .q(tgl_s)
    );

    // Detect a toggle edge; issue the pulse and the count together.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            tgl_prev  <= 1'b0;
            dst_pulse <= 1'b0;
            dst_count <= '0;
        end else begin
            tgl_prev  <= tgl_s;
            dst_pulse <= tgl_s ^ tgl_prev;
            if (tgl_s ^ tgl_prev) dst_count <= held_q;
        end
    end

    AST_COUNT_ONLY_WITH_PULSE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !$stable(dst_count) |-> dst_pulse); // R4
    AST_PULSE_NEEDS_TOGGLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        $rose(dst_pulse) |-> $past(tgl_s) != $past(tgl_prev)); // R2
endmodule

// File: rtl/dma_stream_regs.sv
// Pipelined Wishbone register port that streams data between a core and a DMA engine.
// Holds a start control, synchronized DMA status bits, a word count and two
// dual-clock queues. Every strobe is accepted at once and acknowledged one cycle later.
// Assumes: bus_clk is the DMA-side clock; dma_done and dma_ovf may be asynchronous.
module dma_stream_regs
    import dma_stream_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int ADR_W = 8
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             wb_cyc,
    input  logic             wb_stb,
    input  logic             wb_we,
    input  logic [ADR_W-1:0] wb_adr,
    input  logic [DW-1:0]    wb_dat_i,
    output logic [DW-1:0]    wb_dat_o,
    output logic             wb_ack,
    output logic             wb_stall,
    output logic             wb_err,
    output logic             wb_rty,
    output logic             wb_int,
    input  logic             dma_done,
    input  logic             dma_ovf,
    input  logic             core_clk,
    input  logic             core_rst_n,
    output logic             core_start,
    output logic [DW-1:0]    core_xfer_count,
    input  logic             core_push,
    input  logic [DW-1:0]    core_push_data,
    input  logic             core_push_last,
    output logic             core_c2b_full,
    output logic             core_c2b_empty,
    output logic [AW:0]      core_c2b_count,
    input  logic             core_pop,
    output logic [DW-1:0]    core_pop_data,
    output logic             core_b2c_full,
    output logic             core_b2c_empty,
    output logic [AW:0]      core_b2c_count
);
    localparam int CNT_W = AW + 1;
    localparam int PAD_W = DW - STAT_EMPTY_BIT - 1;

    logic          accept, rd_acc, wr_acc, hit;
    reg_sel_e      sel;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] count_q;
    logic          last_q;
    logic [1:0]    stat_s;
    logic          start_fire, c2b_pop, b2c_push;

    logic [DW:0]      c2b_rd_data;
    logic             c2b_rd_empty, c2b_rd_full;
    logic [CNT_W-1:0] c2b_rd_count;
    logic             b2c_wr_full, b2c_wr_empty;
    logic [CNT_W-1:0] b2c_wr_count;

    assign wb_stall = 1'b0;
    assign wb_err   = 1'b0;
    assign wb_rty   = 1'b0;
    assign wb_int   = 1'b0;

    assign accept = wb_cyc && wb_stb;
    assign rd_acc = accept && !wb_we;
    assign wr_acc = accept && wb_we;
    assign hit    = (wb_adr[1:0] == 2'b00) && (wb_adr[ADR_W-1:5] == '0);
    assign sel    = reg_sel_e'(wb_adr[4:2]);

    assign start_fire = wr_acc && hit && (sel == SEL_CTRL) && wb_dat_i[CTRL_START_BIT];
    assign c2b_pop    = rd_acc && hit && (sel == SEL_C2B_DATA) && !c2b_rd_empty;
    assign b2c_push   = wr_acc && hit && (sel == SEL_B2C_DATA);

    // Select the word a read returns.
    always_comb begin
        rd_word = '0;
        if (hit) begin
            case (sel)
                SEL_CTRL: begin
                    rd_word[CTRL_DONE_BIT] = stat_s[0];
                    rd_word[CTRL_OVF_BIT]  = stat_s[1];
                end
                SEL_COUNT:    rd_word = count_q;
                SEL_C2B_DATA: rd_word = c2b_rd_empty ? '0 : c2b_rd_data[DW-1:0];
                SEL_C2B_LAST: rd_word[0] = last_q;
                SEL_C2B_STAT: rd_word = {PAD_W'(0), c2b_rd_empty, c2b_rd_full,
                                         (STAT_FULL_BIT)'(c2b_rd_count)};
                SEL_B2C_STAT: rd_word = {PAD_W'(0), b2c_wr_empty, b2c_wr_full,
                                         (STAT_FULL_BIT)'(b2c_wr_count)};
                default:      rd_word = '0;
            endcase
        end
    end

    // Acknowledge, read data, word count and end-marker registers.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            wb_ack   <= 1'b0;
            wb_dat_o <= '0;
            count_q  <= '0;
            last_q   <= 1'b0;
        end else begin
            wb_ack <= accept;
            if (rd_acc) wb_dat_o <= rd_word;
            if (wr_acc && hit && (sel == SEL_COUNT)) count_q <= wb_dat_i;
            if (c2b_pop) last_q <= c2b_rd_data[DW];
        end
    end

    dma_sync_vec #(.W(2)) u_stat_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d({dma_ovf, dma_done}), .q(stat_s)
    );

    dma_start_xing #(.CW(DW)) u_start (
        .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_fire(start_fire),
        .src_count(count_q), .dst_clk(core_clk), .dst_rst_n(core_rst_n),
        .dst_pulse(core_start), .dst_count(core_xfer_count)
    );

    dma_fifo_cdc #(.DW(DW + 1), .AW(AW)) u_c2b (
        .wr_clk(core_clk), .wr_rst_n(core_rst_n), .wr_en(core_push),
        .wr_data({core_push_last, core_push_data}), .wr_full(core_c2b_full),
        .wr_empty(core_c2b_empty), .wr_count(core_c2b_count),
        .rd_clk(bus_clk), .rd_rst_n(bus_rst_n), .rd_en(c2b_pop),
        .rd_data(c2b_rd_data), .rd_empty(c2b_rd_empty), .rd_full(c2b_rd_full),
        .rd_count(c2b_rd_count)
    );

    dma_fifo_cdc #(.DW(DW), .AW(AW)) u_b2c (
        .wr_clk(bus_clk), .wr_rst_n(bus_rst_n), .wr_en(b2c_push),
        .wr_data(wb_dat_i), .wr_full(b2c_wr_full), .wr_empty(b2c_wr_empty),
        .wr_count(b2c_wr_count), .rd_clk(core_clk), .rd_rst_n(core_rst_n),
        .rd_en(core_pop), .rd_data(core_pop_data), .rd_empty(core_b2c_empty),
        .rd_full(core_b2c_full), .rd_count(core_b2c_count)
    );

    AST_ACK_AFTER_STROBE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        accept |=> wb_ack); // R1
    AST_NO_STRAY_ACK: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !accept |=> !wb_ack); // R1
    AST_EMPTY_READ_ZERO: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rd_acc && hit && sel == SEL_C2B_DATA && c2b_rd_empty) |=> wb_dat_o == '0); // R6
    AST_EMPTY_READ_KEEPS_LAST: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rd_acc && hit && sel == SEL_C2B_DATA && c2b_rd_empty) |=> $stable(last_q)); // R6
endmodule

// File: tb/dma_stream_regs_test.sv
module dma_stream_regs_test;
    localparam int DEPTH = 256;

    logic        bclk = 1'b0, cclk = 1'b0;
    logic        bus_rst_n = 1'b0, core_rst_n = 1'b0;
    logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
    logic [7:0]  wb_adr = '0;
    logic [31:0] wb_dat_i = '0;
    logic [31:0] wb_dat_o;
    logic        wb_ack, wb_stall, wb_err, wb_rty, wb_int;
    logic        dma_done = 0, dma_ovf = 0;
    logic        core_start;
    logic [31:0] core_xfer_count;
    logic        core_push = 0, core_push_last = 0;
    logic [31:0] core_push_data = '0;
    logic        core_c2b_full, core_c2b_empty, core_pop = 0;
    logic [8:0]  core_c2b_count, core_b2c_count;
    logic [31:0] core_pop_data;
    logic        core_b2c_full, core_b2c_empty;

    int n_chk = 0, n_fail = 0, n_pulse = 0;
    logic last_ack;

    always #5 bclk = ~bclk;
    always #3.5 cclk = ~cclk;

    dma_stream_regs uut (
        .bus_clk(bclk), .bus_rst_n(bus_rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
        .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o),
        .wb_ack(wb_ack), .wb_stall(wb_stall), .wb_err(wb_err), .wb_rty(wb_rty),
        .wb_int(wb_int), .dma_done(dma_done), .dma_ovf(dma_ovf), .core_clk(cclk),
        .core_rst_n(core_rst_n), .core_start(core_start),
        .core_xfer_count(core_xfer_count), .core_push(core_push),
        .core_push_data(core_push_data), .core_push_last(core_push_last),
        .core_c2b_full(core_c2b_full), .core_c2b_empty(core_c2b_empty),
        .core_c2b_count(core_c2b_count), .core_pop(core_pop),
        .core_pop_data(core_pop_data), .core_b2c_full(core_b2c_full),
        .core_b2c_empty(core_b2c_empty), .core_b2c_count(core_b2c_count)
    );

    always @(negedge cclk) if (core_start === 1'b1) n_pulse++;

    function automatic logic [31:0] bpat(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'hA5A50000;
    endfunction
    function automatic logic [31:0] cpat(input int i);
        return 32'(i) * 32'h01010107 + 32'h3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge bclk);
        wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = a; wb_dat_i = d;
        @(negedge bclk);
        last_ack = wb_ack;
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
    endtask

    task automatic wb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge bclk);
        wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = a;
        @(negedge bclk);
        d = wb_dat_o; last_ack = wb_ack;
        wb_cyc = 0; wb_stb = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge bclk);
    endtask

    task automatic core_push_word(input logic [31:0] d, input logic l);
        @(negedge cclk);
        core_push = 1; core_push_data = d; core_push_last = l;
        @(negedge cclk);
        core_push = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int p0;
        repeat (5) @(negedge bclk);
        bus_rst_n = 1; core_rst_n = 1;
        @(negedge bclk);

        // Reset state
        chk("R1 reset ack", {31'b0, wb_ack}, 32'd0);
        chk("R1 tied outputs", {28'b0, wb_stall, wb_err, wb_rty, wb_int}, 32'd0);
        chk("R9 reset core flags", {core_c2b_empty, core_b2c_empty, core_c2b_full,
            core_b2c_full, core_c2b_count, core_b2c_count}, {2'b11, 2'b00, 18'd0});
        wb_read(8'h10, rd); chk("R8 reset c2b status", rd, 32'h0002_0000);
        chk("R1 ack one cycle after read", {31'b0, last_ack}, 32'd1);
        @(negedge bclk);
        chk("R1 ack dropped after strobe", {31'b0, wb_ack}, 32'd0);
        wb_read(8'h18, rd); chk("R8 reset b2c status", rd, 32'h0002_0000);

        // Word count and start pulse
        wb_write(8'h04, 32'h1234_5678);
        wb_read(8'h04, rd); chk("R4 count readback", rd, 32'h1234_5678);
        wb_write(8'h00, 32'h0);
        settle();
        chk("R2 write 0 gives no pulse", n_pulse, 0);
        chk("R4 count not delivered without start", core_xfer_count, 32'h0);
        for (int k = 1; k <= 5; k++) begin
            wb_write(8'h04, 32'h1000_0000 * k + k);
            wb_write(8'h00, 32'h1);
            settle();
            chk("R2 one pulse per start", n_pulse, k);
            chk("R4 count delivered with start", core_xfer_count, 32'h1000_0000 * k + k);
        end
        wb_write(8'h04, 32'h55);
        settle();
        chk("R4 count held until next start", core_xfer_count, 32'h5000_0005);
        wb_read(8'h00, rd); chk("R2 start bit reads 0", rd & 32'h1, 32'h0);

        // DMA status bits, all four combinations
        for (int s = 0; s < 4; s++) begin
            dma_done = s[0]; dma_ovf = s[1];
            settle();
            wb_read(8'h00, rd); chk("R3 status bits", rd, {29'b0, s[1], s[0], 1'b0});
        end
        p0 = n_pulse;
        dma_done = 0; dma_ovf = 1;
        settle();
        wb_write(8'h00, 32'h6);
        settle();
        wb_read(8'h00, rd); chk("R3 write to status bits ignored", rd, 32'h4);
        chk("R2 no pulse for bit0 clear", n_pulse, p0);

        // Bus-to-core queue: fill, overflow, drain
        for (int i = 0; i < DEPTH; i++) wb_write(8'h14, bpat(i));
        wb_write(8'h14, 32'hDEAD_BEEF);
        settle();
        wb_read(8'h18, rd); chk("R8 b2c full status", rd, 32'h0001_0100);
        chk("R9 core sees b2c full", {core_b2c_full, core_b2c_empty, 21'b0, core_b2c_count},
            {2'b10, 21'b0, 9'd256});
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge cclk);
            chk("R7 R10 b2c order", core_pop_data, bpat(i));
            core_pop = 1;
        end
        @(negedge cclk);
        core_pop = 0;
        chk("R7 full write dropped", {31'b0, core_b2c_empty}, 32'd1);
        settle();
        wb_read(8'h18, rd); chk("R8 b2c empty status", rd, 32'h0002_0000);

        // Core-to-bus queue: partial, fill, overflow, drain
        for (int i = 0; i < 3; i++) core_push_word(cpat(i), (i % 16) == 15);
        settle();
        wb_read(8'h10, rd); chk("R8 c2b partial count", rd, 32'h3);
        chk("R9 core c2b count", {23'b0, core_c2b_count}, 32'd3);
        for (int i = 3; i < DEPTH; i++) core_push_word(cpat(i), (i % 16) == 15);
        chk("R9 core sees c2b full", {31'b0, core_c2b_full}, 32'd1);
        core_push_word(32'hBAD0_0BAD, 1'b0);
        settle();
        wb_read(8'h10, rd); chk("R8 R9 c2b full status", rd, 32'h0001_0100);
        for (int i = 0; i < DEPTH; i++) begin
            wb_read(8'h08, rd); chk("R5 R10 c2b order", rd, cpat(i));
            wb_read(8'h0C, rd); chk("R5 end marker", rd, {31'b0, (i % 16) == 15});
        end
        wb_read(8'h08, rd); chk("R6 empty read returns 0", rd, 32'h0);
        wb_read(8'h0C, rd); chk("R6 empty read keeps marker", rd, 32'h1);
        settle();
        wb_read(8'h10, rd); chk("R6 R8 c2b empty status", rd, 32'h0002_0000);
        chk("R9 core sees c2b empty", {31'b0, core_c2b_empty}, 32'd1);

        // Unmapped addresses
        wb_read(8'h1C, rd); chk("R11 offset 0x1C", rd, 32'h0);
        wb_read(8'h06, rd); chk("R11 misaligned", rd, 32'h0);
        wb_read(8'h44, rd); chk("R11 high bits", rd, 32'h0);
        chk("R1 tied outputs at end", {28'b0, wb_stall, wb_err, wb_rty, wb_int}, 32'd0);

        finish_run();
    end
endmodule